// File: doc/BRIEF.md
# Virtual-Output-Queue Crossbar Matching Scheduler

This block is the central matcher of an input-queued crossbar. Each input keeps one queue per output, so a packet stuck behind a busy output never holds up traffic bound for an idle one. Each cycle the scheduler receives one request bit per input/output pair. The bit is set when that per-output queue is non-empty. The scheduler returns a conflict-free connection pattern that configures the crossbar for the next 64-bit chunk slot. A new match is computed in every slot.

The match is built over a bounded number of request/grant/accept passes. In the first pass every output grants one requesting input, chosen in round-robin order from its own grant pointer. Every input that received grants accepts one of them, chosen in round-robin order from its own accept pointer. Later passes consider only the inputs and outputs still left unmatched. The pass count is a parameter, so the full decision fits a fixed time budget. Pointers move only on acceptances made in the first pass. Because of this rule the arbiters fall out of step with one another and every queue is served fairly. The nominal size is 32 ports.

Top module: `voq_match_sched`

## Requirements
- R1: After every clock edge, each input (row `i`, bits `i*NPORT +: NPORT` of `match_o`) is connected to at most one output.
- R2: After every clock edge, each output (bit `j` of every row) is connected to at most one input.
- R3: A connection (bit `i*NPORT+j` of `match_o`) is set only if input `i` requested output `j` (the same bit of `req_i`) at the preceding clock edge.
- R4: `match_o` is registered. It shows the match for the `req_i` sampled at the latest clock edge. A synchronous active-high `rst` clears the match and sets every grant and accept pointer to 0.
- R5: A cycle with no requests gives an empty match and leaves every pointer unchanged.
- R6: An output grants the requesting free input with the lowest index at or after its grant pointer, wrapping from NPORT-1 to 0.
- R7: An input accepts the granting output with the lowest index at or after its accept pointer, wrapping from NPORT-1 to 0.
- R8: Only an acceptance made in the first pass moves pointers. The output's grant pointer becomes the accepted input plus one, and the input's accept pointer becomes the granted output plus one, both modulo NPORT. Grants that are not accepted, and acceptances made in later passes, move nothing.
- R9: Passes after the first run the same grant/accept rules, restricted to inputs and outputs that are still unmatched. Their connections are added to the match. There are `NITER` passes in total.
- R10: `in_busy_o[i]` is the OR of row `i` of `match_o`, and `out_busy_o[j]` is the OR of column `j`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | NPORT*NPORT | Request matrix; bit i*NPORT+j set when input i holds data for output j |
| match_o | output | NPORT*NPORT | Connection matrix, same bit layout as req_i |
| in_busy_o | output | NPORT | Input i is connected this slot |
| out_busy_o | output | NPORT | Output j is connected this slot |

## Verification
The bench builds the scheduler with NPORT=4 and NITER=2. At that size, every grant and accept pointer value, including the wrap from port 3 back to 0, can be reached with a few hand-traced request patterns. Full request matrices leave an input and an output unmatched after the first pass. This is where the second pass does its work, and where the two-pass limit leaves one pair unserved. Repeated identical requests show the pointers rotating service. Idle cycles and resets placed between patterns show the pointer state being held or cleared.

// File: rtl/voq_sched_pkg.sv
package voq_sched_pkg;

    // Widest port count the pointer type can hold.
    localparam int MAX_PORTS = 64;
    localparam int IDX_W     = $clog2(MAX_PORTS);

    typedef logic [IDX_W-1:0] port_idx_t;

    // Result of one round-robin choice.
    typedef struct packed {
        logic      hit;
        port_idx_t idx;
    } pick_t;

    // Position one past a port, wrapping at the port count.
    function automatic port_idx_t ptr_after(port_idx_t p, int nports);
        port_idx_t r;
        if (int'(p) + 1 >= nports) r = '0;
        else                       r = p + port_idx_t'(1);
        return r;
    endfunction

endpackage

// File: rtl/rr_pick.sv
module rr_pick
    import voq_sched_pkg::*;
#(
    parameter int N = 32
) (
    input  logic [N-1:0] req,
    input  port_idx_t    ptr,
    output logic [N-1:0] gnt,
    output pick_t        pick
);

    always_comb begin
        int idx;
        gnt  = '0;
        pick = '0;
        for (int k = 0; k < N; k++) begin
            idx = int'(ptr) + k;
            if (idx >= N) idx = idx - N;
            if (!pick.hit && req[idx]) begin
                pick.hit = 1'b1;
                pick.idx = port_idx_t'(idx);
                gnt[idx] = 1'b1;
            end
        end
    end

    always_comb begin
        AST_PICK_IN_REQ: assert ((gnt & ~req) == '0) else $error("grant without request"); // R6
        AST_PICK_ONEHOT: assert ($onehot0(gnt)) else $error("multiple grants");           // R7
    end

endmodule

// File: rtl/match_pass.sv
module match_pass
    import voq_sched_pkg::*;
#(
    parameter int N = 32
) (
    input  logic [N*N-1:0] req,
    input  logic [N-1:0]   in_free,
    input  logic [N-1:0]   out_free,
    input  port_idx_t      gptr [N],
    input  port_idx_t      aptr [N],
    output logic [N*N-1:0] acc,
    output logic [N-1:0]   in_took,
    output logic [N-1:0]   out_took,
    output pick_t          in_pick [N],
    output pick_t          out_pick [N]
);

    logic [N-1:0] col_req [N];   // per output: which free inputs ask for it
    logic [N-1:0] col_gnt [N];   // per output: granted input (one-hot)
    logic [N-1:0] row_gnt [N];   // per input: outputs granting it
    logic [N-1:0] row_acc [N];   // per input: accepted output (one-hot)

    always_comb begin
        for (int j = 0; j < N; j++)
            for (int i = 0; i < N; i++)
                col_req[j][i] = req[i*N + j] & in_free[i] & out_free[j];
    end

    for (genvar j = 0; j < N; j++) begin : g_out
        rr_pick #(.N(N)) u_grant (
            .req  (col_req[j]),
            .ptr  (gptr[j]),
            .gnt  (col_gnt[j]),
            .pick (out_pick[j])
        );
    end

    always_comb begin
        for (int i = 0; i < N; i++)
            for (int j = 0; j < N; j++)
                row_gnt[i][j] = col_gnt[j][i];
    end

    for (genvar i = 0; i < N; i++) begin : g_in
        rr_pick #(.N(N)) u_accept (
            .req  (row_gnt[i]),
            .ptr  (aptr[i]),
            .gnt  (row_acc[i]),
            .pick (in_pick[i])
        );
    end

    always_comb begin
        out_took = '0;
        for (int i = 0; i < N; i++) begin
            acc[i*N +: N] = row_acc[i];
            in_took[i]    = |row_acc[i];
            out_took      = out_took | row_acc[i];
        end
    end

    always_comb begin
        AST_ACC_FREE_IN: assert ((in_took & ~in_free) == '0) else $error("busy input accepted");    // R9
        AST_ACC_FREE_OUT: assert ((out_took & ~out_free) == '0) else $error("busy output granted"); // R9
    end

endmodule

// File: rtl/voq_match_sched.sv
module voq_match_sched
    import voq_sched_pkg::*;
#(
    parameter int NPORT = 32,
    parameter int NITER = 3
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [NPORT*NPORT-1:0] req_i,
    output logic [NPORT*NPORT-1:0] match_o,
    output logic [NPORT-1:0]       in_busy_o,
    output logic [NPORT-1:0]       out_busy_o
);

    localparam int NN = NPORT * NPORT;

    logic [NPORT-1:0] in_free  [NITER+1];
    logic [NPORT-1:0] out_free [NITER+1];
    logic [NN-1:0]    acc      [NITER];

    port_idx_t gptr_q [NPORT];
    port_idx_t aptr_q [NPORT];

    pick_t            first_in_pick  [NPORT];
    pick_t            first_out_pick [NPORT];
    logic [NPORT-1:0] first_out_took;

    logic [NN-1:0] match_next, match_q;

    assign in_free[0]  = '1;
    assign out_free[0] = '1;

    for (genvar k = 0; k < NITER; k++) begin : g_pass
        logic [NPORT-1:0] in_took, out_took;
        pick_t            in_pick  [NPORT];
        pick_t            out_pick [NPORT];

        match_pass #(.N(NPORT)) u_pass (
            .req      (req_i),
            .in_free  (in_free[k]),
            .out_free (out_free[k]),
            .gptr     (gptr_q),
            .aptr     (aptr_q),
            .acc      (acc[k]),
            .in_took  (in_took),
            .out_took (out_took),
            .in_pick  (in_pick),
            .out_pick (out_pick)
        );

        assign in_free[k+1]  = in_free[k]  & ~in_took;
        assign out_free[k+1] = out_free[k] & ~out_took;

        if (k == 0) begin : g_first
            assign first_in_pick  = in_pick;
            assign first_out_pick = out_pick;
            assign first_out_took = out_took;
        end
    end

    always_comb begin
        match_next = '0;
        for (int k = 0; k < NITER; k++) match_next = match_next | acc[k];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            match_q <= '0;
            for (int p = 0; p < NPORT; p++) begin
                gptr_q[p] <= '0;
                aptr_q[p] <= '0;
            end
        end else begin
            match_q <= match_next;
            for (int p = 0; p < NPORT; p++) begin
                if (first_in_pick[p].hit)
                    aptr_q[p] <= ptr_after(first_in_pick[p].idx, NPORT);
                if (first_out_took[p])
                    gptr_q[p] <= ptr_after(first_out_pick[p].idx, NPORT);
            end
        end
    end

    logic [NPORT-1:0] col_q [NPORT];

    always_comb begin
        out_busy_o = '0;
        for (int i = 0; i < NPORT; i++) begin
            in_busy_o[i] = |match_q[i*NPORT +: NPORT];
            out_busy_o   = out_busy_o | match_q[i*NPORT +: NPORT];
            for (int j = 0; j < NPORT; j++) col_q[j][i] = match_q[i*NPORT + j];
        end
    end

    assign match_o = match_q;

    // Pointer state flattened for stability checks.
    logic [NPORT*IDX_W-1:0] gptr_flat, aptr_flat;
    always_comb begin
        for (int p = 0; p < NPORT; p++) begin
            gptr_flat[p*IDX_W +: IDX_W] = gptr_q[p];
            aptr_flat[p*IDX_W +: IDX_W] = aptr_q[p];
        end
    end

    for (genvar a = 0; a < NPORT; a++) begin : g_chk
        AST_ROW_ONE_OUT: assert property (@(posedge clk) disable iff (rst)
            $onehot0(match_q[a*NPORT +: NPORT])) else $error("input %0d over-matched", a); // R1
        AST_COL_ONE_IN: assert property (@(posedge clk) disable iff (rst)
            $onehot0(col_q[a])) else $error("output %0d over-matched", a); // R2
    end

    AST_MATCH_REQUESTED: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((match_o & ~$past(req_i)) == '0)) else $error("unrequested pair"); // R3

    AST_RESET_CLEAR: assert property (@(posedge clk)
        rst |=> (match_o == '0)) else $error("match not cleared"); // R4

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (req_i == '0) |=> (match_o == '0 && $stable(gptr_flat) && $stable(aptr_flat)))
        else $error("idle cycle changed state"); // R5

endmodule

// File: tb/tb_voq_match_sched.sv
module tb_voq_match_sched;

    localparam int NPORT = 4;
    localparam int NITER = 2;
    localparam int NN    = NPORT * NPORT;
    localparam int NVEC  = 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [NN-1:0] req = '0;
    logic [NN-1:0] match;
    logic [NPORT-1:0] in_busy, out_busy;

    int checks   = 0;
    int failures = 0;

    always #10 clk = ~clk;

    voq_match_sched #(.NPORT(NPORT), .NITER(NITER)) dut (
        .clk        (clk),
        .rst        (rst),
        .req_i      (req),
        .match_o    (match),
        .in_busy_o  (in_busy),
        .out_busy_o (out_busy)
    );

    // Consecutive slots from reset; expected values traced by hand from
    // R6, R7, R8 and R9 (all pointers start at 0).
    localparam logic [NN-1:0] REQ_T [NVEC] = '{
        16'h0000, 16'h0013, 16'h0013, 16'h0013,
        16'hFFFF, 16'h0000, 16'h8000, 16'hFFFF
    };
    localparam logic [NN-1:0] EXP_T [NVEC] = '{
        16'h0000, 16'h0001, 16'h0012, 16'h0001,
        16'h0124, 16'h0000, 16'h8000, 16'h1248
    };

    task automatic check_match(logic [NN-1:0] exp, string tag);
        logic [NPORT-1:0] ein, eout;
        checks++;
        if (match !== exp) begin
            failures++;
            $display("FAIL %s match actual=%h expected=%h", tag, match, exp);
        end
        ein  = '0;
        eout = '0;
        for (int i = 0; i < NPORT; i++) begin
            ein[i] = |exp[i*NPORT +: NPORT];
            eout   = eout | exp[i*NPORT +: NPORT];
        end
        checks++;
        if (in_busy !== ein || out_busy !== eout) begin
            failures++;
            $display("FAIL R10 %s busy actual=%b/%b expected=%b/%b",
                     tag, in_busy, out_busy, ein, eout);
        end
    endtask

    task automatic slot(logic [NN-1:0] r);
        @(negedge clk);
        req = r;
        @(posedge clk);
        #1;
    endtask

    initial begin
        #(20 * 5000);
        failures++;
        $display("FAIL watchdog R4 actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        // R4: reset clears the match even while every pair requests.
        req = '1;
        repeat (3) @(posedge clk);
        #1;
        check_match('0, "R4 reset");
        @(negedge clk);
        rst = 1'b0;
        req = '0;

        // Table walk: R1 R2 R3 R5 R6 R7 R8 R9 checked against traced values.
        for (int v = 0; v < NVEC; v++) begin
            slot(REQ_T[v]);
            check_match(EXP_T[v], $sformatf("R6_R7_R8_R9 vec%0d", v));
            checks++;
            if ((match & ~REQ_T[v]) != '0) begin
                failures++;
                $display("FAIL R3 vec%0d actual=%h expected_subset_of=%h", v, match, REQ_T[v]);
            end
        end

        // R4 latency: before the next edge the old match is still shown.
        @(negedge clk);
        req = '0;
        #1;
        check_match(16'h1248, "R4 hold before edge");
        @(posedge clk);
        #1;
        check_match('0, "R5 idle after edge");

        // R8 rotation again, then reset returns pointers to 0 (R4).
        slot(16'hFFFF);
        @(negedge clk);
        rst = 1'b1;
        req = 16'h0013;
        @(posedge clk);
        #1;
        check_match('0, "R4 reset mid-run");
        @(negedge clk);
        rst = 1'b0;
        @(posedge clk);
        #1;
        check_match(16'h0001, "R4 pointers cleared");
        slot(16'h0013);
        check_match(16'h0012, "R8 pointer moved");

        // R5: idle slots leave pointers, so the next pattern matches as before.
        slot(16'h0000);
        slot(16'h0000);
        check_match('0, "R5 idle");
        slot(16'h0013);
        check_match(16'h0001, "R5 pointers kept");

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule